// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a supervisory timer that software must service inside a time window. A 24-bit down counter is loaded from a programmable reload value and counts down once every four clocks while the watchdog runs. Software keeps it alive with a two-write service sequence to a dedicated register: first the key 0xAA, then the key 0x55. Only the complete pair reloads the counter.

A malformed sequence while the watchdog runs is a fault. So is a service that arrives while the counter is still above the window threshold in reset mode, a protected write to the reload value made too early, and the counter reaching zero. Each fault sets a sticky timeout flag and, in reset mode, raises a reset request that stays high until the block itself is reset. When the counter falls to the warning threshold, a sticky warning flag drives the interrupt output.

Setting the enable bit does not start the counter. The first complete service sequence made while enable is set starts it. Until then, malformed sequences are harmless.

Top module: `win_watchdog`

## Requirements
- R1: After reset the reload value is 0xFF. A write to the reload register (address 1) with a value below 0xFF stores 0xFF, and any other value is stored unchanged.
- R2: A write of 0xAA to the service register (address 2, low byte) followed by a write of 0x55 there as the very next write loads the counter from the reload value. It is visible on `count_o` after the clock edge that takes the 0x55.
- R3: While running, the counter drops by one on every fourth clock edge after a reload, so it reads reload − floor(n/4) n edges after the reload. It holds at zero.
- R4: Control bit 0 (enable) alone does not start the counter. The first valid service made with enable set starts it. Before that, malformed sequences set no flag and request no reset.
- R5: While running, any write after 0xAA other than 0x55 to the service register sets the timeout flag on the next edge. In reset mode, the reset request rises on the second edge after that write.
- R6: While running, once the counter is at or below the warning threshold (address 3, reset 0), the warning flag and `irq_o` rise one edge later.
- R7: While running, a counter at zero sets the timeout flag one edge later. With control bit 1 (reset mode) also set, the reset request rises the edge after that. With bit 1 clear, no reset request is made.
- R8: In reset mode, a valid service while the counter is above the window threshold (address 4, reset 0xFFFFFF) is a fault with the timing of R5. A service at or below the window is not a fault.
- R9: With control bit 2 (protect) set, a reload-register write while running, and while the counter is not below both the warning and the window thresholds, is a fault with the timing of R5, and the written value is discarded. Otherwise the write is accepted.
- R10: Control bits 0 and 1 cannot be cleared by software. Writing control bit 3 or bit 4 as one clears the timeout or warning flag, unless a setting condition holds in the same cycle. Apart from that, both flags and the reset request persist until `rst_ni`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and watchdog clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe, one write per cycle |
| addr_i | input | 3 | Register address: 0 control, 1 reload, 2 service, 3 warning, 4 window |
| wdata_i | input | 24 | Write data |
| irq_o | output | 1 | Warning interrupt (sticky warning flag) |
| wdt_rst_o | output | 1 | Reset request, held until `rst_ni` |
| timeout_flag_o | output | 1 | Sticky timeout flag |
| count_o | output | 24 | Current counter value |

## Verification
The assertions assume that each write strobe lasts exactly one cycle and that the address only takes the five decoded values. They also assume that `rst_ni` is the only way the reset request falls, which makes them valid only until the system controller acts on that request. The stimulus drives every write for a single clock, changing inputs on the falling edge. It uses only the decoded addresses. It applies a fresh reset between scenarios instead of expecting the block to recover from a fault by itself.

// File: rtl/wwd_pkg.sv
package wwd_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL   = 3'd0,
        REG_RELOAD = 3'd1,
        REG_FEED   = 3'd2,
        REG_WARN   = 3'd3,
        REG_WINDOW = 3'd4
    } reg_sel_e;

    localparam logic [7:0] KEY_FIRST  = 8'hAA;
    localparam logic [7:0] KEY_SECOND = 8'h55;

    localparam int CTL_RUN      = 0;
    localparam int CTL_RSTEN    = 1;
    localparam int CTL_LOCK     = 2;
    localparam int CTL_CLR_TO   = 3;
    localparam int CTL_CLR_WARN = 4;

    typedef enum logic {
        FS_IDLE,
        FS_ARMED
    } feed_st_e;

endpackage

// File: rtl/wwd_prescaler.sv
module wwd_prescaler #(
    parameter int PRESC = 4
) (
    input  logic clk,
    input  logic rst_ni,
    input  logic run_i,
    input  logic restart_i,
    output logic tick_o
);
    localparam int PW = (PRESC > 1) ? $clog2(PRESC) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRESC - 1);

    logic [PW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = run_i && (cnt_q == LAST);
        cnt_d  = cnt_q + 1'b1;
        if (restart_i || !run_i || tick_o) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    generate
        if (PRESC > 1) begin : g_spacing
            // R3
            tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_ni)
                tick_o |=> !tick_o);
        end
    endgenerate

endmodule

// File: rtl/wwd_feed_seq.sv
module wwd_feed_seq
    import wwd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        byte_i,
    output logic              feed_ok_o,
    output logic              feed_bad_o
);
    feed_st_e st_d, st_q;
    logic     to_feed;

    always_comb begin
        to_feed    = wr_en_i && (addr_i == REG_FEED);
        feed_ok_o  = (st_q == FS_ARMED) && to_feed && (byte_i == KEY_SECOND);
        feed_bad_o = (st_q == FS_ARMED) && wr_en_i && !feed_ok_o;
        st_d       = st_q;
        if (wr_en_i) begin
            if ((st_q == FS_IDLE) && to_feed && (byte_i == KEY_FIRST)) st_d = FS_ARMED;
            else                                                       st_d = FS_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) st_q <= FS_IDLE;
        else         st_q <= st_d;
    end

    // R2
    arm_origin_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        $rose(st_q == FS_ARMED) |-> $past(wr_en_i && addr_i == REG_FEED && byte_i == KEY_FIRST));

endmodule

// File: rtl/wwd_regs.sv
module wwd_regs
    import wwd_pkg::*;
#(
    parameter int CW       = 24,
    parameter int TC_FLOOR = 255
) (
    input  logic              clk,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CW-1:0]     wdata_i,
    input  logic              tc_block_i,
    output logic              run_en_o,
    output logic              rst_en_o,
    output logic              lock_o,
    output logic              clr_to_o,
    output logic              clr_warn_o,
    output logic [CW-1:0]     reload_o,
    output logic [CW-1:0]     warn_o,
    output logic [CW-1:0]     window_o
);
    localparam logic [CW-1:0] FLOOR = CW'(TC_FLOOR);

    typedef struct packed {
        logic          run_en;
        logic          rst_en;
        logic          lock;
        logic [CW-1:0] reload;
        logic [CW-1:0] warn;
        logic [CW-1:0] window;
    } regs_t;

    regs_t r_d, r_q;
    logic  ctl_wr;

    always_comb begin
        r_d    = r_q;
        ctl_wr = wr_en_i && (addr_i == REG_CTRL);
        if (ctl_wr) begin
            r_d.run_en = r_q.run_en | wdata_i[CTL_RUN];
            r_d.rst_en = r_q.rst_en | wdata_i[CTL_RSTEN];
            r_d.lock   = wdata_i[CTL_LOCK];
        end
        if (wr_en_i && (addr_i == REG_RELOAD) && !tc_block_i) begin
            r_d.reload = (wdata_i < FLOOR) ? FLOOR : wdata_i;
        end
        if (wr_en_i && (addr_i == REG_WARN))   r_d.warn   = wdata_i;
        if (wr_en_i && (addr_i == REG_WINDOW)) r_d.window = wdata_i;
        clr_to_o   = ctl_wr && wdata_i[CTL_CLR_TO];
        clr_warn_o = ctl_wr && wdata_i[CTL_CLR_WARN];
    end

    always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q.run_en <= 1'b0;
            r_q.rst_en <= 1'b0;
            r_q.lock   <= 1'b0;
            r_q.reload <= FLOOR;
            r_q.warn   <= '0;
            r_q.window <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign run_en_o = r_q.run_en;
    assign rst_en_o = r_q.rst_en;
    assign lock_o   = r_q.lock;
    assign reload_o = r_q.reload;
    assign warn_o   = r_q.warn;
    assign window_o = r_q.window;

    // R10
    run_sticky_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        r_q.run_en |=> r_q.run_en);
    // R10
    rsten_sticky_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        r_q.rst_en |=> r_q.rst_en);
    // R1
    reload_floor_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        r_q.reload >= FLOOR);
    // R9
    reload_block_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        tc_block_i |=> $stable(r_q.reload));

endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
    import wwd_pkg::*;
#(
    parameter int CW       = 24,
    parameter int PRESC    = 4,
    parameter int TC_FLOOR = 255
) (
    input  logic              clk,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CW-1:0]     wdata_i,
    output logic              irq_o,
    output logic              wdt_rst_o,
    output logic              timeout_flag_o,
    output logic [CW-1:0]     count_o
);
    typedef struct packed {
        logic [CW-1:0] count;
        logic          running;
        logic          tof;
        logic          warnf;
        logic          pend;
        logic          rst_req;
    } core_t;

    core_t s_d, s_q;

    logic          run_en, rst_en, lock, clr_to, clr_warn;
    logic [CW-1:0] reload, warn, window;
    logic          feed_ok, feed_bad, tick;
    logic          prot_hit, early_hit, seq_err, zero_hit, fault;

    wwd_regs #(.CW(CW), .TC_FLOOR(TC_FLOOR)) u_regs (
        .clk        (clk),
        .rst_ni     (rst_ni),
        .wr_en_i    (wr_en_i),
        .addr_i     (addr_i),
        .wdata_i    (wdata_i),
        .tc_block_i (prot_hit),
        .run_en_o   (run_en),
        .rst_en_o   (rst_en),
        .lock_o     (lock),
        .clr_to_o   (clr_to),
        .clr_warn_o (clr_warn),
        .reload_o   (reload),
        .warn_o     (warn),
        .window_o   (window)
    );

    wwd_feed_seq u_feed (
        .clk        (clk),
        .rst_ni     (rst_ni),
        .wr_en_i    (wr_en_i),
        .addr_i     (addr_i),
        .byte_i     (wdata_i[7:0]),
        .feed_ok_o  (feed_ok),
        .feed_bad_o (feed_bad)
    );

    wwd_prescaler #(.PRESC(PRESC)) u_presc (
        .clk       (clk),
        .rst_ni    (rst_ni),
        .run_i     (s_q.running),
        .restart_i (feed_ok),
        .tick_o    (tick)
    );

    always_comb begin
        s_d       = s_q;
        prot_hit  = wr_en_i && (addr_i == REG_RELOAD) && lock && s_q.running &&
                    !((s_q.count < warn) && (s_q.count < window));
        early_hit = feed_ok && s_q.running && rst_en && (s_q.count > window);
        seq_err   = feed_bad && s_q.running;
        zero_hit  = s_q.running && (s_q.count == '0);
        fault     = prot_hit || early_hit || seq_err || zero_hit;

        if (feed_ok) begin
            s_d.count = reload;
        end else if (tick && (s_q.count != '0)) begin
            s_d.count = s_q.count - 1'b1;
        end
        s_d.running = s_q.running | (feed_ok & run_en);

        if (clr_warn) s_d.warnf = 1'b0;
        if (s_q.running && (s_q.count <= warn)) s_d.warnf = 1'b1;

        if (clr_to) s_d.tof = 1'b0;
        if (fault)  s_d.tof = 1'b1;

        s_d.pend    = fault;
        s_d.rst_req = s_q.rst_req | (s_q.pend & rst_en);
    end

    always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q.count   <= CW'(TC_FLOOR);
            s_q.running <= 1'b0;
            s_q.tof     <= 1'b0;
            s_q.warnf   <= 1'b0;
            s_q.pend    <= 1'b0;
            s_q.rst_req <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign irq_o          = s_q.warnf;
    assign wdt_rst_o      = s_q.rst_req;
    assign timeout_flag_o = s_q.tof;
    assign count_o        = s_q.count;

    // R3
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        (!tick && !feed_ok) |=> $stable(s_q.count));
    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        (tick && !feed_ok && s_q.count != '0) |=> (s_q.count == $past(s_q.count) - 1'b1));
    // R2
    reload_load_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        feed_ok |=> (s_q.count == $past(reload)));
    // R4
    run_gate_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        s_q.running |-> run_en);
    // R7
    rst_mode_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        s_q.rst_req |-> rst_en);
    // R5
    rst_delay_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        $rose(s_q.rst_req) |-> $past(s_q.pend));
    // R10
    rst_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        s_q.rst_req |=> s_q.rst_req);
    // R10
    tof_sticky_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        (s_q.tof && !clr_to) |=> s_q.tof);
    // R4
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        !s_q.running |=> !s_q.pend);

endmodule

// File: tb/win_watchdog_test.sv
`timescale 1ns/1ps
module win_watchdog_test;
    import wwd_pkg::*;

    localparam int CW = 24;

    logic          clk = 1'b0;
    logic          rst_ni = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    addr = '0;
    logic [CW-1:0] wdata = '0;
    logic          irq, wrst, tof;
    logic [CW-1:0] count;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    win_watchdog uut (
        .clk            (clk),
        .rst_ni         (rst_ni),
        .wr_en_i        (wr_en),
        .addr_i         (addr),
        .wdata_i        (wdata),
        .irq_o          (irq),
        .wdt_rst_o      (wrst),
        .timeout_flag_o (tof),
        .count_o        (count)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [CW-1:0] d);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic feed();
        wr(3'd2, 24'hAA);
        wr(3'd2, 24'h55);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_ni = 1'b0;
        idle(3);
        rst_ni = 1'b1;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
        end
    end

    initial begin
        int n;
        int exp_c;
        do_reset();

        // R1 reset state
        chk("R1 count at reset", count, 32'hFF);
        chk("R10 tof at reset", tof, 0);
        chk("R6 irq at reset", irq, 0);
        chk("R7 rst at reset", wrst, 0);

        // R1 R2 sweep of reload values, not running
        for (int v = 0; v <= 300; v++) begin
            wr(3'd1, CW'(v));
            feed();
            chk("R1 R2 reload clamp", count, (v < 255) ? 255 : v);
        end
        wr(3'd1, 24'hABCDEF);
        feed();
        chk("R2 large reload", count, 32'hABCDEF);
        idle(8);
        chk("R4 idle counter holds", count, 32'hABCDEF);

        // R4 enable alone, malformed sequences ignored
        wr(3'd0, 24'h3);
        idle(8);
        chk("R4 enable alone holds", count, 32'hABCDEF);
        wr(3'd2, 24'hAA);
        wr(3'd3, 24'h0);
        wr(3'd2, 24'hAA);
        wr(3'd2, 24'h56);
        idle(3);
        chk("R4 no tof before start", tof, 0);
        chk("R4 no rst before start", wrst, 0);

        // R3 R6 countdown and warning
        wr(3'd1, 24'd300);
        wr(3'd3, 24'd290);
        feed();
        for (int j = 0; j <= 60; j++) begin
            exp_c = 300 - j / 4;
            chk("R3 countdown", count, exp_c);
            chk("R6 warning", irq, (j >= 1 && (300 - (j - 1) / 4) <= 290) ? 1 : 0);
            @(negedge clk);
        end

        // R8 window: feed allowed, then early feed
        feed();
        chk("R8 feed under window", tof, 0);
        chk("R2 reload on feed", count, 300);
        wr(3'd4, 24'd280);
        feed();
        chk("R8 early tof", tof, 1);
        chk("R8 early rst not yet", wrst, 0);
        @(negedge clk);
        chk("R8 early rst", wrst, 1);
        wr(3'd0, 24'h0);
        idle(3);
        chk("R10 rst held", wrst, 1);
        chk("R10 tof held", tof, 1);

        // R5 malformed sequence while running
        do_reset();
        wr(3'd0, 24'h3);
        feed();
        wr(3'd2, 24'hAA);
        wr(3'd3, 24'd5);
        chk("R5 tof", tof, 1);
        chk("R5 rst not yet", wrst, 0);
        @(negedge clk);
        chk("R5 rst second edge", wrst, 1);

        // R7 interrupt mode timeout
        do_reset();
        wr(3'd0, 24'h1);
        feed();
        n = 0;
        while (count != 0 && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk("R3 edges to zero", n, 1020);
        chk("R7 tof not yet", tof, 0);
        @(negedge clk);
        chk("R7 tof at zero", tof, 1);
        chk("R6 irq at zero", irq, 1);
        idle(3);
        chk("R7 no rst in irq mode", wrst, 0);
        chk("R3 holds at zero", count, 0);
        feed();
        wr(3'd0, 24'h19);
        chk("R10 tof cleared", tof, 0);
        chk("R10 irq cleared", irq, 0);

        // R7 reset mode timeout
        do_reset();
        wr(3'd0, 24'h3);
        wr(3'd1, 24'd0);
        feed();
        n = 0;
        while (count != 0 && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk("R1 R3 clamped timeout", n, 1020);
        @(negedge clk);
        chk("R7 tof", tof, 1);
        chk("R7 rst not yet", wrst, 0);
        @(negedge clk);
        chk("R7 rst", wrst, 1);

        // R9 protected reload write too early
        do_reset();
        wr(3'd0, 24'h7);
        wr(3'd3, 24'd250);
        wr(3'd4, 24'd250);
        wr(3'd1, 24'd400);
        feed();
        wr(3'd1, 24'd500);
        chk("R9 protect tof", tof, 1);
        feed();
        chk("R9 value discarded", count, 400);

        // R9 protected reload write accepted below both thresholds
        do_reset();
        wr(3'd0, 24'h7);
        wr(3'd3, 24'd250);
        wr(3'd4, 24'd250);
        wr(3'd1, 24'd400);
        feed();
        n = 0;
        while (count >= 250 && n < 2000) begin
            @(negedge clk);
            n++;
        end
        wr(3'd1, 24'd500);
        chk("R9 accepted no tof", tof, 0);
        feed();
        chk("R9 accepted value", count, 500);
        chk("R8 in-window feed no rst", wrst, 0);

        // R10 enable bits cannot be cleared
        do_reset();
        wr(3'd0, 24'h3);
        wr(3'd0, 24'h0);
        wr(3'd4, 24'd100);
        feed();
        idle(8);
        chk("R10 run stays set", count, 253);
        feed();
        chk("R10 rst_en stays set tof", tof, 1);
        @(negedge clk);
        chk("R10 rst_en stays set rst", wrst, 1);

        done = 1'b1;
        summary();
    end

endmodule